// File: doc/BRIEF.md
# Unaligned Word Access Unit

This unit sits between a processor-side load/store port and a memory that only accepts whole, aligned rows one word wide. The processor may issue a word read or write at any byte address. When the address falls on a row boundary, the unit performs a single row transaction. When the word straddles two rows, the unit splits the access. A read fetches both rows and joins the needed bytes into one word. A write reads both rows, merges the new bytes into the correct lanes, and then writes both rows back.

Byte order is little-endian. The byte at the start address lands in bits 7:0 of the word, and byte lane k of a row holds byte address row*BYTES+k. A per-access strict input turns misalignment into an error: the unit flags it for one cycle and touches no memory.

The memory port is a request/acknowledge interface. A request and its address, write flag and write data stay stable until an acknowledge cycle. On a read, the row data is valid during the acknowledge cycle. The processor side sees a busy/done handshake.

Top module: `uwa_top`

## Requirements
- R1: A read with byte offset (address modulo BYTES) equal to 0 issues exactly one memory read, of row address>>OFF_W, and returns that row on rdata_o.
- R2: A write with offset 0 issues exactly one memory write, which replaces the whole row with wdata_i.
- R3: A read with a non-zero offset issues two memory reads, lower row first and then the next row. rdata_o byte k equals memory byte address+k.
- R4: A write with a non-zero offset issues four transactions in this order: read lower row, read upper row, write lower row, write upper row. Only bytes address..address+BYTES-1 change.
- R5: busy_o is high from the cycle after an accepted request through the cycle of the final acknowledge. done_o pulses for one cycle in the next cycle with busy_o low, and rdata_o is valid with it for reads.
- R6: With strict_i high and a non-zero offset, err_o pulses for one cycle in the cycle after the request. No memory request is made, done_o stays low and memory is unchanged.
- R7: With strict_i high and offset 0, the access proceeds exactly as in R1/R2.
- R8: req_i is ignored while busy_o is high.
- R9: After reset, busy_o, done_o, err_o and mem_req_o are low.
- R10: While mem_req_o is high and mem_ack_i is low, mem_addr_o and mem_we_o hold their values. On writes, mem_wdata_o also holds.
- R11: The upper row of a straddling access at the last row is row 0 (address arithmetic wraps).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, sampled when not busy |
| we_i | input | 1 | 1 = write, 0 = read |
| strict_i | input | 1 | Reject misaligned accesses |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | DATA_W | Write word |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle misalignment rejection |
| rdata_o | output | DATA_W | Read word |
| mem_req_o | output | 1 | Memory row request |
| mem_we_o | output | 1 | Memory row write |
| mem_addr_o | output | ADDR_W-OFF_W | Memory row address |
| mem_wdata_o | output | DATA_W | Memory row write data |
| mem_ack_i | input | 1 | Memory acknowledge |
| mem_rdata_i | input | DATA_W | Memory row read data |

## Verification
A wrong sequencer state appears at the memory port first. It shows up as a missing or extra transaction, a second row that is not row+1, or a write before both reads, all visible within one acknowledge of the fault. Faulty lane selection shows up as wrong bytes on rdata_o in the done cycle of a straddling read. For a write, it shows up as corrupted neighbour bytes, which the next read of either row exposes. A stuck or early completion is seen as done_o arriving with a transaction count that does not match the offset.

// File: rtl/uwa_pkg.sv
package uwa_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_LO,
    ST_RD_HI,
    ST_WR_LO,
    ST_WR_HI
  } uwa_state_e;
endpackage

// File: rtl/uwa_lane.sv
// Byte selection (read join) and lane merge (write) across a pair of rows.
module uwa_lane #(
  parameter int DATA_W = 32,
  localparam int BYTES = DATA_W / 8,
  localparam int OFF_W = $clog2(BYTES)
) (
  input  logic [DATA_W-1:0] lo_i,
  input  logic [DATA_W-1:0] hi_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [OFF_W-1:0]  off_i,
  output logic [DATA_W-1:0] rword_o,
  output logic [DATA_W-1:0] new_lo_o,
  output logic [DATA_W-1:0] new_hi_o
);
  localparam int PAIR_W = 2 * DATA_W;

  logic [PAIR_W-1:0] pair;
  logic [PAIR_W-1:0] merged;

  assign pair = {hi_i, lo_i};

  // read join: output byte k comes from pair byte k+off
  for (genvar k = 0; k < BYTES; k++) begin : g_rd
    logic [OFF_W:0] src;
    assign src = (OFF_W+1)'(k) + {1'b0, off_i};
    assign rword_o[k*8 +: 8] = pair[{src, 3'b000} +: 8];
  end

  // write merge: pair byte j takes wdata byte j-off inside the window
  for (genvar j = 0; j < 2 * BYTES; j++) begin : g_wr
    logic             in_win;
    logic [OFF_W-1:0] widx;
    assign in_win = ({1'b0, off_i} <= (OFF_W+1)'(j)) &&
                    ((OFF_W+1)'(j) < ({1'b0, off_i} + (OFF_W+1)'(BYTES)));
    assign widx   = OFF_W'(j) - off_i;
    assign merged[j*8 +: 8] = in_win ? wdata_i[{widx, 3'b000} +: 8] : pair[j*8 +: 8];
  end

  assign new_lo_o = merged[DATA_W-1:0];
  assign new_hi_o = merged[PAIR_W-1:DATA_W];
endmodule

// File: rtl/uwa_fsm.sv
module uwa_fsm
  import uwa_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  localparam int BYTES = DATA_W / 8,
  localparam int OFF_W = $clog2(BYTES),
  localparam int ROW_W = ADDR_W - OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic              strict_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ROW_W-1:0]  mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  // lane datapath
  output logic [DATA_W-1:0] lo_o,
  output logic [DATA_W-1:0] hi_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [OFF_W-1:0]  off_o,
  input  logic [DATA_W-1:0] rword_i,
  input  logic [DATA_W-1:0] new_lo_i,
  input  logic [DATA_W-1:0] new_hi_i
);
  uwa_state_e        state_q;
  logic [ROW_W-1:0]  row_q;
  logic [OFF_W-1:0]  off_q;
  logic              we_q;
  logic [DATA_W-1:0] wdata_q, lo_q, hi_q, rdata_q;
  logic              done_q, err_q;
  logic              aligned_q, in_mis;

  assign aligned_q = (off_q == '0);
  assign in_mis    = (addr_i[OFF_W-1:0] != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      row_q   <= '0;
      off_q   <= '0;
      we_q    <= 1'b0;
      wdata_q <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (req_i) begin
            if (strict_i && in_mis) begin
              err_q <= 1'b1;
            end else begin
              row_q   <= addr_i[ADDR_W-1:OFF_W];
              off_q   <= addr_i[OFF_W-1:0];
              we_q    <= we_i;
              wdata_q <= wdata_i;
              state_q <= (we_i && !in_mis) ? ST_WR_LO : ST_RD_LO;
            end
          end
        end
        ST_RD_LO: begin
          if (mem_ack_i) begin
            lo_q <= mem_rdata_i;
            if (aligned_q) begin
              rdata_q <= mem_rdata_i;
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              state_q <= ST_RD_HI;
            end
          end
        end
        ST_RD_HI: begin
          if (mem_ack_i) begin
            hi_q <= mem_rdata_i;
            if (we_q) begin
              state_q <= ST_WR_LO;
            end else begin
              rdata_q <= rword_i;
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end
          end
        end
        ST_WR_LO: begin
          if (mem_ack_i) begin
            if (aligned_q) begin
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              state_q <= ST_WR_HI;
            end
          end
        end
        ST_WR_HI: begin
          if (mem_ack_i) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = done_q;
  assign err_o       = err_q;
  assign rdata_o     = rdata_q;
  assign mem_req_o   = (state_q != ST_IDLE);
  assign mem_we_o    = (state_q == ST_WR_LO) || (state_q == ST_WR_HI);
  assign mem_addr_o  = ((state_q == ST_RD_HI) || (state_q == ST_WR_HI)) ? row_q + 1'b1 : row_q;
  assign mem_wdata_o = (state_q == ST_WR_HI) ? new_hi_i : new_lo_i;

  assign lo_o    = lo_q;
  assign hi_o    = (state_q == ST_RD_HI) ? mem_rdata_i : hi_q;
  assign wdata_o = wdata_q;
  assign off_o   = off_q;

  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)
                                   && (!mem_we_o || $stable(mem_wdata_o))));

  assert_done_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && !mem_req_o));

  assert_err_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!mem_req_o && !done_o));

  // R4/R11: the upper write follows the lower one at the next row, wrapping
  assert_upper_next_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o && mem_ack_i && !aligned_q && state_q == ST_WR_LO)
      |=> (mem_req_o && mem_we_o && mem_addr_o == ROW_W'($past(mem_addr_o) + 1'b1)));
endmodule

// File: rtl/uwa_top.sv
module uwa_top #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  localparam int BYTES = DATA_W / 8,
  localparam int OFF_W = $clog2(BYTES),
  localparam int ROW_W = ADDR_W - OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic              strict_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ROW_W-1:0]  mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  logic [DATA_W-1:0] lo, hi, wdata_q, rword, new_lo, new_hi;
  logic [OFF_W-1:0]  off;

  uwa_fsm #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_fsm (
    .clk_i, .rst_ni, .req_i, .we_i, .strict_i, .addr_i, .wdata_i,
    .busy_o, .done_o, .err_o, .rdata_o,
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_ack_i, .mem_rdata_i,
    .lo_o(lo), .hi_o(hi), .wdata_o(wdata_q), .off_o(off),
    .rword_i(rword), .new_lo_i(new_lo), .new_hi_i(new_hi)
  );

  uwa_lane #(.DATA_W(DATA_W)) i_lane (
    .lo_i(lo), .hi_i(hi), .wdata_i(wdata_q), .off_i(off),
    .rword_o(rword), .new_lo_o(new_lo), .new_hi_o(new_hi)
  );
endmodule

// File: tb/test_uwa_top.sv
`timescale 1ns/1ps
module test_uwa_top;
  localparam int ROWS = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we_s = 1'b0, strict_s = 1'b0;
  logic [7:0] addr_s = '0;
  logic [31:0] wdata_s = '0;
  logic busy, done, err, mem_req, mem_we, mem_ack;
  logic [31:0] rdata, mem_wdata, mem_rdata;
  logic [5:0] mem_addr;

  logic [31:0] mem [ROWS];
  logic [7:0]  sh [256];
  int lat = 0, cnt = 0;
  int txn = 0, log_n = 0;
  logic       log_we [4];
  logic [5:0] log_addr [4];
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  uwa_top i_uwa_top (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we_s), .strict_i(strict_s),
    .addr_i(addr_s), .wdata_i(wdata_s), .busy_o(busy), .done_o(done), .err_o(err),
    .rdata_o(rdata), .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata)
  );

  // memory model with variable acknowledge latency
  assign mem_rdata = mem[mem_addr];
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
      cnt <= 0;
    end else if (mem_req && !mem_ack) begin
      if (cnt >= lat) begin mem_ack <= 1'b1; cnt <= 0; end
      else cnt <= cnt + 1;
    end else begin
      mem_ack <= 1'b0;
    end
  end
  always @(posedge clk) begin
    if (mem_req && mem_ack) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      txn = txn + 1;
      if (log_n < 4) begin
        log_we[log_n] = mem_we;
        log_addr[log_n] = mem_addr;
        log_n = log_n + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string msg);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s", msg);
    end
  endtask

  task automatic access(input logic w, input logic st, input logic [7:0] a,
                        input logic [31:0] wd, input bit junk, input bit exp_err,
                        input int exp_txn, input string tag);
    logic [31:0] exp_rd;
    logic [5:0]  row;
    bit busy_ok;
    int cyc;
    exp_rd = {sh[a + 8'd3], sh[a + 8'd2], sh[a + 8'd1], sh[a]};
    row = a[7:2];
    @(negedge clk);
    req = 1'b1; we_s = w; strict_s = st; addr_s = a; wdata_s = wd;
    txn = 0; log_n = 0;
    @(negedge clk);
    if (junk) begin we_s = 1'b1; strict_s = 1'b0; addr_s = 8'h40; wdata_s = '1; end
    else req = 1'b0;
    if (exp_err) begin
      chk(err === 1'b1 && busy === 1'b0,
          $sformatf("%s err=%b busy=%b exp err=1 busy=0 @%h", tag, err, busy, a));
      @(negedge clk);
      chk(txn == 0 && done === 1'b0 && err === 1'b0,
          $sformatf("%s txn=%0d done=%b err=%b exp 0/0/0", tag, txn, done, err));
    end else begin
      busy_ok = 1'b1;
      cyc = 0;
      while (done !== 1'b1 && cyc < 100) begin
        if (busy !== 1'b1) busy_ok = 1'b0;
        @(negedge clk);
        cyc++;
      end
      req = 1'b0;
      chk(done === 1'b1 && busy === 1'b0 && busy_ok,
          $sformatf("R5 %s done=%b busy=%b busy_held=%b exp 1/0/1", tag, done, busy, busy_ok));
      chk(txn == exp_txn, $sformatf("%s txn=%0d exp %0d @%h", tag, txn, exp_txn, a));
      if (!w) begin
        chk(rdata === exp_rd, $sformatf("%s rdata=%h exp %h @%h", tag, rdata, exp_rd, a));
      end else begin
        for (int k = 0; k < 4; k++) sh[a + 8'(k)] = wd[k*8 +: 8];
      end
      if (w && exp_txn == 4) begin
        chk(log_we[0] == 0 && log_we[1] == 0 && log_we[2] == 1 && log_we[3] == 1 &&
            log_addr[0] == row && log_addr[1] == row + 6'd1 &&
            log_addr[2] == row && log_addr[3] == row + 6'd1,
            $sformatf("R4 order %s we=%b%b%b%b addr=%h,%h,%h,%h exp rows %h,%h", tag,
                      log_we[0], log_we[1], log_we[2], log_we[3],
                      log_addr[0], log_addr[1], log_addr[2], log_addr[3], row, row + 6'd1));
      end
      @(negedge clk);
      chk(done === 1'b0, $sformatf("R5 done=%b exp 0 one cycle later", done));
    end
  endtask

  // {we, strict, addr, wdata, exp_err, exp_txn}
  localparam int NV = 15;
  localparam logic [45:0] VEC [NV] = '{
    {1'b0, 1'b0, 8'h10, 32'h0,         1'b0, 3'd1},
    {1'b0, 1'b0, 8'h11, 32'h0,         1'b0, 3'd2},
    {1'b0, 1'b0, 8'h13, 32'h0,         1'b0, 3'd2},
    {1'b1, 1'b0, 8'h22, 32'hA1B2C3D4,  1'b0, 3'd4},
    {1'b0, 1'b0, 8'h22, 32'h0,         1'b0, 3'd2},
    {1'b0, 1'b0, 8'h20, 32'h0,         1'b0, 3'd1},
    {1'b0, 1'b0, 8'h24, 32'h0,         1'b0, 3'd1},
    {1'b1, 1'b0, 8'h30, 32'h11223344,  1'b0, 3'd1},
    {1'b0, 1'b0, 8'h30, 32'h0,         1'b0, 3'd1},
    {1'b0, 1'b1, 8'h31, 32'h0,         1'b1, 3'd0},
    {1'b1, 1'b1, 8'h35, 32'hDEADBEEF,  1'b1, 3'd0},
    {1'b0, 1'b1, 8'h34, 32'h0,         1'b0, 3'd1},
    {1'b1, 1'b0, 8'hFE, 32'h55667788,  1'b0, 3'd4},
    {1'b0, 1'b0, 8'hFE, 32'h0,         1'b0, 3'd2},
    {1'b0, 1'b0, 8'h00, 32'h0,         1'b0, 3'd1}
  };

  function automatic string tag_of(input logic [45:0] v);
    if (v[3]) return "R6";
    if (v[44]) return "R7";
    if (v[43:42] == 2'b11 && v[37:36] != 2'b00) return "R11";
    if (v[37:36] == 2'b00) return v[45] ? "R2" : "R1";
    return v[45] ? "R4" : "R3";
  endfunction

  initial begin
    for (int r = 0; r < ROWS; r++) begin
      for (int k = 0; k < 4; k++) begin
        sh[r*4 + k] = 8'((r*4 + k) * 7 + 3);
        mem[r][k*8 +: 8] = 8'((r*4 + k) * 7 + 3);
      end
    end
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && err === 1'b0 && mem_req === 1'b0,
        $sformatf("R9 in reset busy=%b done=%b err=%b req=%b exp 0", busy, done, err, mem_req));
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && err === 1'b0 && mem_req === 1'b0,
        $sformatf("R9 after reset busy=%b done=%b err=%b req=%b exp 0", busy, done, err, mem_req));

    for (int i = 0; i < NV; i++) begin
      lat = i % 3;
      access(VEC[i][45], VEC[i][44], VEC[i][43:36], VEC[i][35:4], 1'b0,
             VEC[i][3], int'(VEC[i][2:0]), tag_of(VEC[i]));
    end

    // R8: a write request held high during a busy read must not be taken
    lat = 2;
    access(1'b0, 1'b0, 8'h45, 32'h0, 1'b1, 1'b0, 2, "R8 busy read");
    access(1'b0, 1'b0, 8'h40, 32'h0, 1'b0, 1'b0, 1, "R8 no stray write");
    // R10: long latency straddling write then readback
    lat = 4;
    access(1'b1, 1'b0, 8'h4B, 32'hCAFEF00D, 1'b0, 1'b0, 4, "R10 slow write");
    access(1'b0, 1'b0, 8'h49, 32'h0, 1'b0, 1'b0, 2, "R10 slow read");
    access(1'b0, 1'b0, 8'h4C, 32'h0, 1'b0, 1'b0, 1, "R4 neighbour");
    // R7: strict aligned write
    lat = 1;
    access(1'b1, 1'b1, 8'h50, 32'h0BADC0DE, 1'b0, 1'b0, 1, "R7 strict write");
    access(1'b0, 1'b0, 8'h50, 32'h0, 1'b0, 1'b0, 1, "R2 readback");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule